// File: doc/BRIEF.md
# Hot-Plug Slot Controller Register Block

This block serves one hot-plug slot behind a downstream or root port. It exposes three 32-bit registers through a plain read/write port: a fixed capabilities word describing the slot hardware, a control word that software writes to steer the slot, and a status word that collects slot events and reports the present latch and card states. Slot inputs (attention button, power fault, latch sensor, card presence) pass through two-flop synchronisers before any event is derived from them.

Every write to the control word is a command. The block holds the new control fields, runs a command timer of `CMD_CYCLES` clocks and, when the timer ends, moves the indicator and power fields onto the slot outputs and posts a command-completed event. The indicator outputs follow 2-bit codes (on, blink, off), and blinking toggles at a rate set by `BLINK_DIV`. One interrupt line is raised when the global hot-plug enable is set and any event is pending with its own enable.

Register addresses on `reg_addr`: 0 = capabilities, 1 = control, 2 = status, 3 reads as zero.

Top module: `hp_slot_regs`

## Requirements
- R1: The capabilities word reads as {slot number in bits 31:19, zeros in 18:7, 1 in bit 6, 0 in bit 5, presence flags in 4:0 (button, power controller, latch sensor, attention indicator, power indicator)}; writes to it have no effect.
- R2: The control word resets to 0x400 and reads back bits 10:0 of the last value written, with bits 31:11 reading zero.
- R3: Status bit 0 is set by a rising edge of the synchronised button input only; status bit 2 (latch) and bit 3 (presence) are set by either edge of their synchronised inputs.
- R4: Status bit 1 is set on every cycle the synchronised fault input is high, so it cannot be cleared while the fault persists; a set in the same cycle as a clear wins.
- R5: Writing 1 to any of status bits 4:0 clears it and writing 0 leaves it; bit 5 shows the synchronised latch state and bit 6 the synchronised presence state, and neither is writable.
- R6: The indicator and power outputs and status bit 4 (command completed) change exactly `CMD_CYCLES` clocks after the clock edge that takes a control write, and never at any other time.
- R7: A control write arriving while a command is pending is accepted, restarts the timer, and only its own fields reach the outputs.
- R8: Indicator codes are 01 = lit, 11 = dark, 10 = toggling every `BLINK_DIV` clocks counted from reset, and 00 keeps the previously applied code (both indicators reset dark).
- R9: Control bit 10 set means slot power off: `slot_pwr_en` is the inverse of the applied bit, and after reset the slot is unpowered.
- R10: `hp_irq` is high exactly when control bit 5 is set and some status bit n (n = 0..4) is set together with control bit n.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select (0 caps, 1 control, 2 status) |
| reg_wr | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| btn_in | input | 1 | Attention button, asynchronous |
| fault_in | input | 1 | Power fault condition, asynchronous |
| latch_in | input | 1 | Retention latch sensor, asynchronous |
| present_in | input | 1 | Card presence, asynchronous |
| attn_led | output | 1 | Attention indicator drive |
| pwr_led | output | 1 | Power indicator drive |
| slot_pwr_en | output | 1 | Slot power enable |
| hp_irq | output | 1 | Hot-plug interrupt |

## Verification
The embedded properties watch, on every cycle, that applied outputs only move on a command-completion cycle, that a completion always latches the completed event, that a persisting fault re-latches its event, that the button event only rises after a synchronised rising edge, that the interrupt never fires without the global enable, and that blink phase only turns at the prescaler wrap. Only the bench scenarios can show the exact command latency, the abandonment of a superseded command, the hold on a reserved indicator code, the blink period, and that writes to the read-only capabilities and state bits leave them intact; its reference model tracks the outputs every clock through those sequences.

// File: rtl/hp_slot_pkg.sv
`timescale 1ns/1ps
package hp_slot_pkg;

  localparam int CTRL_W = 11;
  localparam int EV_N   = 5;
  localparam int IN_N   = 4;

  localparam logic [1:0] ADDR_CAP  = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // Input/event index order: button, fault, latch, presence
  localparam int IDX_BTN   = 0;
  localparam int IDX_FAULT = 1;
  localparam int IDX_LATCH = 2;
  localparam int IDX_PRES  = 3;
  localparam int IDX_CC    = 4;

  typedef enum logic [1:0] {
    IND_RSVD  = 2'b00,
    IND_ON    = 2'b01,
    IND_BLINK = 2'b10,
    IND_OFF   = 2'b11
  } ind_code_e;

  typedef struct packed {
    logic      pwr_off;   // bit 10
    ind_code_e pwr_ind;   // bits 9:8
    ind_code_e attn_ind;  // bits 7:6
    logic [5:0] en;       // bit 5 global, bits 4:0 per event
  } slot_ctrl_t;

  localparam slot_ctrl_t CTRL_RESET = slot_ctrl_t'(11'h400);

  function automatic logic [31:0] cap_word(input logic [4:0] present,
                                           input logic [12:0] slot_num);
    return {slot_num, 12'b0, 1'b1, 1'b0, present};
  endfunction

  function automatic ind_code_e ind_resolve(input ind_code_e req,
                                            input ind_code_e cur);
    return (req == IND_RSVD) ? cur : req;
  endfunction

  function automatic logic ind_drive(input ind_code_e code, input logic phase);
    case (code)
      IND_ON:    return 1'b1;
      IND_BLINK: return phase;
      default:   return 1'b0;
    endcase
  endfunction

  function automatic logic irq_calc(input slot_ctrl_t c, input logic [EV_N-1:0] ev);
    return c.en[5] & (|(ev & c.en[EV_N-1:0]));
  endfunction

endpackage

// File: rtl/hp_sync_edge.sv
`timescale 1ns/1ps
module hp_sync_edge #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] level,
  output logic [N-1:0] rise,
  output logic [N-1:0] change
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= async_in[i];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign level[i]  = sync_q;
    assign rise[i]   = sync_q & ~prev_q;
    assign change[i] = sync_q ^ prev_q;
  end

endmodule

// File: rtl/hp_cmd_engine.sv
`timescale 1ns/1ps
module hp_cmd_engine
  import hp_slot_pkg::*;
#(
  parameter int CMD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_start,
  input  slot_ctrl_t ctrl_q,
  output ind_code_e  attn_code,
  output ind_code_e  pwr_code,
  output logic       pwr_off,
  output logic       cmd_busy,
  output logic       cmd_done
);

  localparam int CNT_W = (CMD_CYCLES > 1) ? $clog2(CMD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CMD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  assign cmd_done = cmd_busy && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_busy <= 1'b0;
      cnt_q    <= '0;
    end else if (cmd_start) begin
      cmd_busy <= 1'b1;
      cnt_q    <= CNT_LOAD;
    end else if (cmd_busy) begin
      if (cnt_q == '0) cmd_busy <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attn_code <= IND_OFF;
      pwr_code  <= IND_OFF;
      pwr_off   <= 1'b1;
    end else if (cmd_done) begin
      attn_code <= ind_resolve(ctrl_q.attn_ind, attn_code);
      pwr_code  <= ind_resolve(ctrl_q.pwr_ind, pwr_code);
      pwr_off   <= ctrl_q.pwr_off;
    end
  end

  p_hold_between_cmds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_done |=> $stable({attn_code, pwr_code, pwr_off}));

  p_restart_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (CMD_CYCLES > 1) && cmd_start |=> cmd_busy && !cmd_done);

  p_code_never_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (attn_code != IND_RSVD) && (pwr_code != IND_RSVD));

endmodule

// File: rtl/hp_blink.sv
`timescale 1ns/1ps
module hp_blink #(
  parameter int DIV = 256
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);

  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] presc_q;
  logic          wrap;

  assign wrap = (presc_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      phase   <= 1'b0;
    end else if (wrap) begin
      presc_q <= '0;
      phase   <= ~phase;
    end else begin
      presc_q <= presc_q + 1'b1;
    end
  end

  p_phase_turns_at_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(phase));

endmodule

// File: rtl/hp_slot_regs.sv
`timescale 1ns/1ps
module hp_slot_regs
  import hp_slot_pkg::*;
#(
  parameter int          CMD_CYCLES  = 16,
  parameter int          BLINK_DIV   = 256,
  parameter logic [4:0]  CAP_PRESENT = 5'b11111,
  parameter logic [12:0] SLOT_NUM    = 13'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        btn_in,
  input  logic        fault_in,
  input  logic        latch_in,
  input  logic        present_in,
  output logic        attn_led,
  output logic        pwr_led,
  output logic        slot_pwr_en,
  output logic        hp_irq
);

  localparam logic [31:0] CAP_VALUE = cap_word(CAP_PRESENT, SLOT_NUM);

  logic [IN_N-1:0] sync_lvl, sync_rise, sync_chg;
  logic [EV_N-1:0] ev_q, ev_set, ev_clr;
  slot_ctrl_t      ctrl_q;
  logic            ctrl_wr, stat_wr;
  logic            cmd_busy, cmd_done, pwr_off, blink_phase;
  ind_code_e       attn_code, pwr_code;
  ind_code_e       codes [2];
  logic [1:0]      leds;
  logic [20:0]     wdata_unused;

  assign wdata_unused = reg_wdata[31:11];

  hp_sync_edge #(.N(IN_N)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({present_in, latch_in, fault_in, btn_in}),
    .level(sync_lvl), .rise(sync_rise), .change(sync_chg)
  );

  assign ctrl_wr = reg_wr && (reg_addr == ADDR_CTRL);
  assign stat_wr = reg_wr && (reg_addr == ADDR_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_RESET;
    else if (ctrl_wr) ctrl_q <= slot_ctrl_t'(reg_wdata[CTRL_W-1:0]);
  end

  hp_cmd_engine #(.CMD_CYCLES(CMD_CYCLES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_start(ctrl_wr), .ctrl_q(ctrl_q),
    .attn_code(attn_code), .pwr_code(pwr_code), .pwr_off(pwr_off),
    .cmd_busy(cmd_busy), .cmd_done(cmd_done)
  );

  // Event sources: button rising edge, fault level, latch/presence either edge
  assign ev_set[IDX_BTN]   = sync_rise[IDX_BTN];
  assign ev_set[IDX_FAULT] = sync_lvl[IDX_FAULT];
  assign ev_set[IDX_LATCH] = sync_chg[IDX_LATCH];
  assign ev_set[IDX_PRES]  = sync_chg[IDX_PRES];
  assign ev_set[IDX_CC]    = cmd_done;
  assign ev_clr = stat_wr ? reg_wdata[EV_N-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ev_q <= '0;
    else        ev_q <= (ev_q & ~ev_clr) | ev_set;
  end

  hp_blink #(.DIV(BLINK_DIV)) u_blink (
    .clk(clk), .rst_n(rst_n), .phase(blink_phase)
  );

  assign codes[0] = attn_code;
  assign codes[1] = pwr_code;
  for (genvar g = 0; g < 2; g++) begin : g_ind
    assign leds[g] = ind_drive(codes[g], blink_phase);
  end

  assign attn_led    = leds[0];
  assign pwr_led     = leds[1];
  assign slot_pwr_en = ~pwr_off;
  assign hp_irq      = irq_calc(ctrl_q, ev_q);

  always_comb begin
    case (reg_addr)
      ADDR_CAP:  reg_rdata = CAP_VALUE;
      ADDR_CTRL: reg_rdata = {21'b0, ctrl_q};
      ADDR_STAT: reg_rdata = {25'b0, sync_lvl[IDX_PRES], sync_lvl[IDX_LATCH], ev_q};
      default:   reg_rdata = '0;
    endcase
  end

  p_irq_needs_global_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hp_irq |-> ctrl_q.en[5]);

  p_done_posts_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_done |=> ev_q[IDX_CC]);

  p_button_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_q[IDX_BTN]) |-> $past(sync_rise[IDX_BTN]));

  p_fault_relatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lvl[IDX_FAULT] |=> ev_q[IDX_FAULT]);

  p_w1c_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr && reg_wdata[IDX_LATCH] && !sync_chg[IDX_LATCH] |=> !ev_q[IDX_LATCH]);

endmodule

// File: tb/hp_slot_regs_bench.sv
`timescale 1ns/1ps
module hp_slot_regs_bench;

  localparam int          N      = 16;
  localparam int          DIV    = 4;
  localparam logic [4:0]  PRES   = 5'b10110;
  localparam logic [12:0] SLOTN  = 13'd37;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic btn_in = 0, fault_in = 0, latch_in = 0, present_in = 0;
  logic attn_led, pwr_led, slot_pwr_en, hp_irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  hp_slot_regs #(.CMD_CYCLES(N), .BLINK_DIV(DIV), .CAP_PRESENT(PRES), .SLOT_NUM(SLOTN)) u_hp_slot_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .btn_in(btn_in),
    .fault_in(fault_in), .latch_in(latch_in), .present_in(present_in),
    .attn_led(attn_led), .pwr_led(pwr_led), .slot_pwr_en(slot_pwr_en),
    .hp_irq(hp_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  logic [10:0] m_ctrl;
  logic [4:0]  m_ev;
  int          m_remain;
  logic [1:0]  m_attn, m_pwr;
  logic        m_off;
  int          m_k;
  logic [3:0]  hist [3];
  logic [3:0]  s_now, s_old;
  logic [4:0]  m_set, m_clr;

  function automatic logic led_of(input logic [1:0] code, input int k);
    if (code == 2'b01) return 1'b1;
    if (code == 2'b10) return ((k / DIV) % 2) == 1;
    return 1'b0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 11'h400; m_ev = '0; m_remain = 0;
      m_attn = 2'b11; m_pwr = 2'b11; m_off = 1'b1; m_k = 0;
      for (int i = 0; i < 3; i++) hist[i] = '0;
    end else begin
      s_now = hist[1]; s_old = hist[2];
      m_set = '0;
      m_set[0] = s_now[0] && !s_old[0];
      m_set[1] = s_now[1];
      m_set[2] = s_now[2] != s_old[2];
      m_set[3] = s_now[3] != s_old[3];
      if (m_remain == 1) begin
        m_set[4] = 1'b1;
        if (m_ctrl[7:6] != 2'b00) m_attn = m_ctrl[7:6];
        if (m_ctrl[9:8] != 2'b00) m_pwr = m_ctrl[9:8];
        m_off = m_ctrl[10];
      end
      m_clr = (reg_wr && reg_addr == 2'd2) ? reg_wdata[4:0] : 5'd0;
      m_ev = (m_ev & ~m_clr) | m_set;
      if (reg_wr && reg_addr == 2'd1) begin
        m_ctrl = reg_wdata[10:0]; m_remain = N;
      end else if (m_remain > 0) m_remain--;
      hist[2] = hist[1]; hist[1] = hist[0];
      hist[0] = {present_in, latch_in, fault_in, btn_in};
      m_k++;
    end
  end

  // every-cycle comparison of the slot outputs
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R8 attn_led model", attn_led, led_of(m_attn, m_k));
      chk("R8 pwr_led model", pwr_led, led_of(m_pwr, m_k));
      chk("R9 slot_pwr_en model", slot_pwr_en, !m_off);
      chk("R10 hp_irq model", hp_irq, m_ctrl[5] && |(m_ev & m_ctrl[4:0]));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic count_toggles(input int cycles, input bit attn, output int n);
    logic last;
    n = 0;
    last = attn ? attn_led : pwr_led;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if ((attn ? attn_led : pwr_led) != last) n++;
      last = attn ? attn_led : pwr_led;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(2'd0, v); chk("R1 caps word", v, {SLOTN, 12'b0, 1'b1, 1'b0, PRES});
    wr(2'd0, 32'h0);
    rd(2'd0, v); chk("R1 caps after write", v, {SLOTN, 12'b0, 1'b1, 1'b0, PRES});
    rd(2'd1, v); chk("R2 control reset", v, 32'h400);
    chk("R9 reset unpowered", slot_pwr_en, 0);
    rd(2'd2, v); chk("R5 status reset", v, 0);

    // power on, power indicator lit, attention blinking
    wr(2'd1, 32'hFFFF_F180);
    repeat (N - 1) @(negedge clk);
    chk("R6 power not yet applied", slot_pwr_en, 0);
    @(negedge clk);
    chk("R6 power applied on time", slot_pwr_en, 1);
    chk("R8 power indicator lit", pwr_led, 1);
    rd(2'd1, v); chk("R2 control readback", v, 32'h180);
    rd(2'd2, v); chk("R6 command completed", v[4], 1);
    count_toggles(4 * DIV, 1, t); chk("R8 blink period", t, 4);

    // reserved attention code keeps blinking
    wr(2'd1, 32'h100);
    repeat (N + 2) @(negedge clk);
    count_toggles(4 * DIV, 1, t); chk("R8 reserved holds blink", t, 4);
    wr(2'd1, 32'h1C0);
    repeat (N + 1) @(negedge clk);
    count_toggles(2 * DIV, 1, t); chk("R8 dark code no toggles", t, 0);
    chk("R8 attention dark", attn_led, 0);

    wr(2'd2, 32'h10);
    rd(2'd2, v); chk("R5 w1c clears completed", v[4], 0);

    // button: rising only
    btn_in = 1; repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R3 button rise sets", v[0], 1);
    wr(2'd2, 32'h0);
    rd(2'd2, v); chk("R5 write zero keeps", v[0], 1);
    wr(2'd2, 32'h01); btn_in = 0; repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R3 button fall ignored", v[0], 0);

    // latch: both edges
    latch_in = 1; repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R3 latch rise sets", v[2], 1); chk("R5 latch state", v[5], 1);
    wr(2'd2, 32'h04); latch_in = 0; repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R3 latch fall sets", v[2], 1); chk("R5 latch state low", v[5], 0);
    present_in = 1; repeat (4) @(negedge clk);
    wr(2'd2, 32'h7F);
    rd(2'd2, v); chk("R5 state bits read-only", v, 32'h40);

    // fault persists
    fault_in = 1; repeat (4) @(negedge clk);
    wr(2'd2, 32'h02);
    rd(2'd2, v); chk("R4 fault relatches", v[1], 1);
    fault_in = 0; repeat (4) @(negedge clk);
    wr(2'd2, 32'h02);
    rd(2'd2, v); chk("R4 fault clears once gone", v[1], 0);

    // interrupt gating
    btn_in = 1; repeat (4) @(negedge clk);
    wr(2'd1, 32'h101);
    repeat (N + 2) @(negedge clk);
    chk("R10 no irq without global enable", hp_irq, 0);
    wr(2'd1, 32'h121);
    chk("R10 irq with global enable", hp_irq, 1);
    wr(2'd2, 32'h01);
    chk("R10 irq drops after clear", hp_irq, 0);
    btn_in = 0;
    repeat (N + 2) @(negedge clk);

    // superseded command
    wr(2'd1, 32'h500);
    repeat (5) @(negedge clk);
    wr(2'd1, 32'h100);
    repeat (N - 7) @(negedge clk);
    chk("R7 abandoned power-off not applied", slot_pwr_en, 1);
    repeat (8) @(negedge clk);
    chk("R7 final command keeps power", slot_pwr_en, 1);
    wr(2'd1, 32'h500);
    repeat (N) @(negedge clk);
    chk("R9 power off applied", slot_pwr_en, 0);
    repeat (4) @(negedge clk);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule